// File: doc/BRIEF.md
# Paging Mode Control Register

This block holds a processor control register whose bit 12 chooses between 48-bit and 57-bit linear addressing. Software write requests carry a proposed value. The block checks each one against a parameter-derived allow mask and against the long-mode state, then either accepts or rejects it. Accepted writes are acknowledged. When a translation-relevant bit changes, the block raises a one-cycle TLB-flush request. Rejected writes leave the register unchanged and produce an error pulse.

From the register, the block derives the effective linear width. It uses that width to judge whether a probe address is canonical. It also performs a second canonical test that always uses 48 bits, for address-valued model-specific registers. A fixed identification word reports the physical width and the linear width the configuration supports. A restore port reloads the register from saved state without any checks. All bits other than bit 12 are plain writable bits, gated only by the allow mask.

Top module: `paging_mode_ctl`

## Requirements
- R1: After reset, `ctl_o` is zero, `lin_width_o` is 48, and `wr_ack_o`, `wr_err_o` and `tlb_flush_o` are low.
- R2: A write that sets any bit outside the allow mask is rejected. The allow mask defaults to bits 0-11 and 13, plus bit 12 only when the 5-level feature and long mode are both configured. On rejection the register keeps its value and `wr_err_o` pulses for one cycle after the request.
- R3: An accepted write loads `wr_data_i` into `ctl_o` at the capturing edge and pulses `wr_ack_o` for one cycle after it. `lin_width_o` is 57 when `ctl_o[12]` is 1 and 48 when it is 0, and it changes in the same cycle as the register.
- R4: While `long_mode_i` is high, a write whose bit 12 differs from the current `ctl_o[12]` is rejected. This blocks clearing the 57-bit enable and also blocks setting it.
- R5: `tlb_flush_o` pulses in the cycle after an accepted write only if some bit of the flush mask changed value. The flush mask defaults to bits 4, 5, 7 and 12.
- R6: `restore_i` loads `restore_data_i` masked by the allow mask, bypassing the long-mode rule. It produces no ack, error or flush, it recomputes `lin_width_o`, and it takes priority over a write in the same cycle.
- R7: `chk_canon_o` is 1 exactly when bits 63 down to (width-1) of `chk_addr_i` are all equal, where width is the current `lin_width_o`.
- R8: `msr_canon_o` applies the R7 rule with the width fixed at 48, whatever the value of `ctl_o`.
- R9: `id_word_o[7:0]` is the physical width and `id_word_o[15:8]` is the supported linear width: 57 with the feature, 48 with long mode but no feature, 32 without long mode. Bits 31:16 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request strobe |
| wr_data_i | input | 32 | Proposed register value |
| long_mode_i | input | 1 | Long mode currently active |
| restore_i | input | 1 | Load saved state without checks |
| restore_data_i | input | 32 | Saved register value |
| chk_addr_i | input | 64 | Address probed for canonical form |
| ctl_o | output | 32 | Current register value |
| lin_width_o | output | 8 | Effective linear width (48 or 57) |
| wr_ack_o | output | 1 | Write accepted pulse |
| wr_err_o | output | 1 | Write rejected pulse |
| tlb_flush_o | output | 1 | Full TLB flush request pulse |
| chk_canon_o | output | 1 | Probe canonical at current width |
| msr_canon_o | output | 1 | Probe canonical at 48 bits |
| id_word_o | output | 32 | Address-size identification word |

## Verification
A corrupted enable bit is visible at once on `lin_width_o` and `chk_canon_o`, so the canonical sweeps at both widths expose it in the cycle the register changes. A wrong acceptance decision shows up one cycle after the request: the ack/error pulse pair is wrong, and `ctl_o` either keeps the old value or takes the new one. A wrong flush comparison appears only as a missing or extra `tlb_flush_o` pulse in that same cycle. For that reason the bench pairs writes that change only masked bits with writes that change only unmasked bits.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned WIDTH_5LVL   = 57;
  localparam int unsigned WIDTH_4LVL   = 48;
  localparam int unsigned WIDTH_LEGACY = 32;

  function automatic logic [7:0] eff_width(input logic la57);
    return la57 ? 8'(WIDTH_5LVL) : 8'(WIDTH_4LVL);
  endfunction

  function automatic logic [7:0] rep_width(input bit long_en, input bit la57_en);
    if (!long_en) return 8'(WIDTH_LEGACY);
    return la57_en ? 8'(WIDTH_5LVL) : 8'(WIDTH_4LVL);
  endfunction
endpackage

// File: rtl/pmc_wr_check.sv
module pmc_wr_check #(
  parameter int unsigned          REG_W    = 32,
  parameter int unsigned          LA57_POS = 12,
  parameter logic [REG_W-1:0]     ALLOW    = '1
) (
  input  logic [REG_W-1:0] cur_i,
  input  logic [REG_W-1:0] nxt_i,
  input  logic             long_mode_i,
  output logic             ok_o
);
  logic rsvd_hit, depth_hit;
  assign rsvd_hit  = |(nxt_i & ~ALLOW);
  // paging depth frozen while long mode is active
  assign depth_hit = long_mode_i && (nxt_i[LA57_POS] != cur_i[LA57_POS]);
  assign ok_o      = !rsvd_hit && !depth_hit;
endmodule

// File: rtl/pmc_canon.sv
module pmc_canon #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned WIDTH  = 48
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              canon_o
);
  localparam int unsigned TOP_N = ADDR_W - WIDTH + 1;
  logic [TOP_N-1:0] top;
  assign top     = addr_i[ADDR_W-1:WIDTH-1];
  assign canon_o = (&top) | ~(|top);
endmodule

// File: rtl/paging_mode_ctl.sv
module paging_mode_ctl
  import pmc_pkg::*;
#(
  parameter int unsigned      REG_W      = 32,
  parameter int unsigned      ADDR_W     = 64,
  parameter int unsigned      PHYS_W     = 46,
  parameter int unsigned      LA57_POS   = 12,
  parameter bit               LONG_EN    = 1'b1,
  parameter bit               LA57_EN    = 1'b1,
  parameter logic [REG_W-1:0] BASE_ALLOW = 32'h0000_2FFF,
  parameter logic [REG_W-1:0] BASE_FLUSH = 32'h0000_00B0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              long_mode_i,
  input  logic              restore_i,
  input  logic [REG_W-1:0]  restore_data_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [REG_W-1:0]  ctl_o,
  output logic [7:0]        lin_width_o,
  output logic              wr_ack_o,
  output logic              wr_err_o,
  output logic              tlb_flush_o,
  output logic              chk_canon_o,
  output logic              msr_canon_o,
  output logic [31:0]       id_word_o
);
  localparam bit               FEAT_ON  = LONG_EN && LA57_EN;
  localparam logic [REG_W-1:0] LA57_BIT = REG_W'(1) << LA57_POS;
  localparam logic [REG_W-1:0] ALLOW    = (BASE_ALLOW & ~LA57_BIT) | (FEAT_ON ? LA57_BIT : '0);
  localparam logic [REG_W-1:0] FLUSH    = BASE_FLUSH | LA57_BIT;
  localparam logic [7:0]       REP_W    = rep_width(LONG_EN, LA57_EN);

  logic [REG_W-1:0] ctl_q;
  logic             ack_q, err_q, flush_q;
  logic             wr_take, wr_ok;
  logic             canon48, canon57;

  assign wr_take = wr_valid_i && !restore_i;

  pmc_wr_check #(.REG_W(REG_W), .LA57_POS(LA57_POS), .ALLOW(ALLOW)) u_wr_check (
    .cur_i       (ctl_q),
    .nxt_i       (wr_data_i),
    .long_mode_i (long_mode_i),
    .ok_o        (wr_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      ack_q   <= wr_take && wr_ok;
      err_q   <= wr_take && !wr_ok;
      flush_q <= wr_take && wr_ok && |((wr_data_i ^ ctl_q) & FLUSH);
      if (restore_i)             ctl_q <= restore_data_i & ALLOW;
      else if (wr_take && wr_ok) ctl_q <= wr_data_i;
    end
  end

  pmc_canon #(.ADDR_W(ADDR_W), .WIDTH(WIDTH_4LVL)) u_canon48 (
    .addr_i  (chk_addr_i),
    .canon_o (canon48)
  );

  generate
    if (FEAT_ON) begin : g_la57
      pmc_canon #(.ADDR_W(ADDR_W), .WIDTH(WIDTH_5LVL)) u_canon57 (
        .addr_i  (chk_addr_i),
        .canon_o (canon57)
      );
    end else begin : g_no_la57
      assign canon57 = canon48;
    end
  endgenerate

  assign ctl_o       = ctl_q;
  assign lin_width_o = eff_width(ctl_q[LA57_POS]);
  assign chk_canon_o = ctl_q[LA57_POS] ? canon57 : canon48;
  assign msr_canon_o = canon48;
  assign wr_ack_o    = ack_q;
  assign wr_err_o    = err_q;
  assign tlb_flush_o = flush_q;
  assign id_word_o   = {16'h0000, REP_W, 8'(PHYS_W)};
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int unsigned      REG_W    = 32,
  parameter int unsigned      LA57_POS = 12,
  parameter logic [REG_W-1:0] ALLOW    = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             long_mode_i,
  input logic             restore_i,
  input logic [REG_W-1:0] ctl_o,
  input logic             wr_ack_o,
  input logic             wr_err_o,
  input logic             tlb_flush_o,
  input logic             chk_canon_o,
  input logic             msr_canon_o
);
  p_mbz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o & ~ALLOW) == '0);

  p_err_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> ctl_o == $past(ctl_o));

  p_ack_err_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ack_o && wr_err_o));

  p_depth_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_mode_i && wr_valid_i && !restore_i) |=> ctl_o[LA57_POS] == $past(ctl_o[LA57_POS]));

  p_flush_on_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> wr_ack_o);

  p_restore_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> !wr_ack_o && !wr_err_o && !tlb_flush_o);

  p_msr_implies_cur_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_canon_o |-> chk_canon_o);

  p_cur48_implies_msr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_canon_o && !ctl_o[LA57_POS]) |-> msr_canon_o);
endmodule

bind paging_mode_ctl pmc_checker #(.REG_W(REG_W), .LA57_POS(LA57_POS), .ALLOW(ALLOW)) u_pmc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .long_mode_i (long_mode_i),
  .restore_i   (restore_i),
  .ctl_o       (ctl_o),
  .wr_ack_o    (wr_ack_o),
  .wr_err_o    (wr_err_o),
  .tlb_flush_o (tlb_flush_o),
  .chk_canon_o (chk_canon_o),
  .msr_canon_o (msr_canon_o)
);

// File: tb/tb_paging_mode_ctl.sv
module tb_paging_mode_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, long_mode = 1'b0, restore = 1'b0;
  logic [31:0] wr_data = '0, restore_data = '0;
  logic [63:0] addr = '0;
  logic [31:0] ctl, ctl_nf, id, id_nf;
  logic [7:0]  width, width_nf;
  logic        ack, err, flush, canon, msr;
  logic        ack_nf, err_nf, flush_nf, canon_nf, msr_nf;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  paging_mode_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .long_mode_i(long_mode), .restore_i(restore), .restore_data_i(restore_data),
    .chk_addr_i(addr), .ctl_o(ctl), .lin_width_o(width), .wr_ack_o(ack),
    .wr_err_o(err), .tlb_flush_o(flush), .chk_canon_o(canon), .msr_canon_o(msr),
    .id_word_o(id));

  paging_mode_ctl #(.LA57_EN(1'b0)) dut_nf (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .long_mode_i(1'b0), .restore_i(1'b0), .restore_data_i(32'h0),
    .chk_addr_i(addr), .ctl_o(ctl_nf), .lin_width_o(width_nf), .wr_ack_o(ack_nf),
    .wr_err_o(err_nf), .tlb_flush_o(flush_nf), .chk_canon_o(canon_nf), .msr_canon_o(msr_nf),
    .id_word_o(id_nf));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ref_canon(input logic [63:0] a, input int w);
    logic [63:0] hi = a >> (w - 1);
    return (hi == 64'h0) || (hi == (64'hFFFF_FFFF_FFFF_FFFF >> (w - 1)));
  endfunction

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic do_write(input logic [31:0] d);
    wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_wr(input string req, input logic a, input logic e,
                           input logic f, input logic [31:0] c);
    chk({req, " ack"}, 64'(ack), 64'(a));
    chk({req, " err"}, 64'(err), 64'(e));
    chk({req, " flush"}, 64'(flush), 64'(f));
    chk({req, " ctl"}, 64'(ctl), 64'(c));
    chk({req, " width"}, 64'(width), c[12] ? 64'd57 : 64'd48);
  endtask

  task automatic sweep(input string req, input int w);
    for (int i = 0; i < 64; i++) begin
      for (int inv = 0; inv < 2; inv++) begin
        addr = (inv != 0) ? ~(64'd1 << i) : (64'd1 << i);
        #1;
        chk({req, " canon"}, 64'(canon), 64'(ref_canon(addr, w)));
        chk("R8 msr canon", 64'(msr), 64'(ref_canon(addr, 48)));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_wr("R1", 1'b0, 1'b0, 1'b0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_wr("R1 post", 1'b0, 1'b0, 1'b0, 32'h0);
    // R9 identification words
    chk("R9 id la57", 64'(id), 64'h0000_392E);
    chk("R9 id 4lvl", 64'(id_nf), 64'h0000_302E);
    sweep("R7 w48", 48);

    // R3 R5 enable 57-bit outside long mode; nf instance must reject bit 12 (R2)
    do_write(32'h0000_1001);
    expect_wr("R3 set la57", 1'b1, 1'b0, 1'b1, 32'h0000_1001);
    chk("R2 nf err", 64'(err_nf), 64'd1);
    chk("R2 nf ctl", 64'(ctl_nf), 64'h0);
    chk("R2 nf width", 64'(width_nf), 64'd48);
    sweep("R7 w57", 57);

    // R5 same value: no flush
    do_write(32'h0000_1001);
    expect_wr("R5 same", 1'b1, 1'b0, 1'b0, 32'h0000_1001);
    // R5 change unmasked bit only
    do_write(32'h0000_1003);
    expect_wr("R5 unmasked", 1'b1, 1'b0, 1'b0, 32'h0000_1003);
    // R2 reserved bits
    do_write(32'h8000_1003);
    expect_wr("R2 bit31", 1'b0, 1'b1, 1'b0, 32'h0000_1003);
    do_write(32'h0000_5003);
    expect_wr("R2 bit14", 1'b0, 1'b1, 1'b0, 32'h0000_1003);
    @(negedge clk);
    expect_wr("R3 pulse ends", 1'b0, 1'b0, 1'b0, 32'h0000_1003);

    // R4 long mode
    long_mode = 1'b1;
    do_write(32'h0000_0003);
    expect_wr("R4 clear", 1'b0, 1'b1, 1'b0, 32'h0000_1003);
    do_write(32'h0000_1013);
    expect_wr("R4 keep R5 bit4", 1'b1, 1'b0, 1'b1, 32'h0000_1013);

    // R6 restore bypasses long-mode rule, masks, silent; beats write
    restore_data = 32'hF000_0021; restore = 1'b1; wr_data = 32'h0000_1013; wr_valid = 1'b1;
    @(negedge clk);
    restore = 1'b0; wr_valid = 1'b0;
    expect_wr("R6 restore", 1'b0, 1'b0, 1'b0, 32'h0000_0021);
    sweep("R7 after R6", 48);
    do_write(32'h0000_1021);
    expect_wr("R4 set", 1'b0, 1'b1, 1'b0, 32'h0000_0021);
    long_mode = 1'b0;
    do_write(32'h0000_0001);
    expect_wr("R5 bit5", 1'b1, 1'b0, 1'b1, 32'h0000_0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule